// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

A 16-bit timer driven by a 32.768 kHz tick enable through a prescaler of /1, /16 or /256. In normal mode it is a reloadable general-purpose timer. It counts up or down, runs free or reloads periodically, and raises an interrupt each time it wraps. Setting one control bit turns it into a watchdog. The counter then reloads from the load register and decrements on every prescaled tick whether or not the enable bit is set. When it steps out of zero it reloads and either emits a one-cycle reset request or raises the interrupt, as the action bit selects.

Software writes three registers through a single write port: load, control and service. The service register keeps the watchdog alive. Only one key value reloads the counter, clears the interrupt and restarts the prescaler. Once watchdog mode is entered, the mode bit, the load register and the prescale field stay frozen until the block is reset. With /256 and a full-scale load, the timeout is roughly 512 seconds.

Top module: `wdog_timer`

## Requirements
- R1: After reset, count is 0, irq and wdt_rst are 0, all control bits are 0 (normal mode, disabled, /1) and the load register is 0.
- R2: In normal mode, a write to address 0 sets both the load register and count to wr_data on the next cycle.
- R3: Control bits [3:2] select the prescaler: 00 gives /1, 01 gives /16, 10 gives /256 and 11 gives /1. While the timer runs, count changes once per that many src_tick pulses, counted from the last reload.
- R4: In normal mode with enable (control bit 7) set and count-up (bit 0) clear, count decrements per prescaled tick. A step from 0 sets irq and loads either the load value (periodic, bit 6 set) or 16'hFFFF (free-running).
- R5: In normal mode with bit 0 set, count increments. A step from 16'hFFFF sets irq and loads either the load value (periodic) or 0.
- R6: Writing control with bit 5 set enters watchdog mode, loads count from the load register and resets the prescaler. From then on count decrements on each prescaled tick regardless of bit 7, and bit 5 cannot be cleared except by reset.
- R7: In watchdog mode, a step from count 0 reloads count from the load register. If control bit 1 is 0, wdt_rst is high for exactly the next cycle. If bit 1 is 1, irq is set instead.
- R8: Writing 16'hB00C to address 2 reloads count from the load register, clears irq and restarts the prescaler. Any other value written there has no effect.
- R9: In watchdog mode, writes to address 0 are ignored, and control writes change only bit 1.
- R10: wdt_rst is never asserted in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | One-cycle enable per 32.768 kHz source period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 load, 1 control, 2 service |
| wr_data | input | 16 | Write data (control uses bits [7:0]) |
| count | output | 16 | Current counter value |
| irq | output | 1 | Sticky interrupt, cleared by a valid service write |
| wdt_rst | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
On every cycle, the assertions check the locks: once the mode bit is set it stays set, and the load register and prescale field stay unchanged. They also check that a valid service write always leaves irq low, and that a reset pulse can only come after a cycle spent in watchdog mode with reset action. The bench scenarios cover the timing itself: the exact tick on which each prescaler steps, the wrap values in both count directions, the number of steps from load to expiry, the single-cycle width of the reset pulse, and the rejection of wrong service keys. These are checked cycle by cycle against a bench model under random writes and directed corner cases.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter logic [CW-1:0] SVC_KEY = 16'hB00C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count,
  output logic          irq,
  output logic          wdt_rst
);
  localparam int B_UP = 0, B_ACT = 1, B_PS = 2, B_WD = 5, B_PER = 6, B_EN = 7;
  localparam logic [PW-1:0] DIV16 = PW'(15), DIV256 = PW'(255);

  logic [7:0]    ctrl_q;
  logic [CW-1:0] load_q;
  logic [PW-1:0] pc, div_m1;

  always_comb
    case (ctrl_q[B_PS+1:B_PS])
      2'b01:   div_m1 = DIV16;
      2'b10:   div_m1 = DIV256;
      default: div_m1 = '0;
    endcase

  wire wd      = ctrl_q[B_WD];
  wire run     = wd | ctrl_q[B_EN];
  wire down    = wd | ~ctrl_q[B_UP];
  wire wr_load = wr_en && wr_addr == 2'd0;
  wire wr_ctrl = wr_en && wr_addr == 2'd1;
  wire wr_svc  = wr_en && wr_addr == 2'd2 && wr_data == SVC_KEY;
  wire enter   = wr_ctrl && !wd && wr_data[B_WD];
  wire ld_new  = wr_load && !wd;
  wire reload  = ld_new | enter | wr_svc;
  wire step    = run && src_tick && (pc >= div_m1) && !reload;
  wire at_end  = down ? (count == '0) : (&count);
  wire expire  = step && at_end;
  wire [CW-1:0] wrap_val = (wd | ctrl_q[B_PER]) ? load_q : (down ? '1 : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (ld_new) load_q <= wr_data;
      if (wr_ctrl)
        ctrl_q <= wd ? {ctrl_q[7:2], wr_data[B_ACT], ctrl_q[0]} : wr_data[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0;
      pc    <= '0;
    end else if (reload) begin
      count <= ld_new ? wr_data : load_q;
      pc    <= '0;
    end else if (run && src_tick) begin
      pc <= step ? '0 : pc + 1'b1;
      if (step) count <= at_end ? wrap_val : (down ? count - 1'b1 : count + 1'b1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq     <= 1'b0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= expire && wd && !ctrl_q[B_ACT];
      if (wr_svc) irq <= 1'b0;
      else if (expire && (!wd || ctrl_q[B_ACT])) irq <= 1'b1;
    end
endmodule

module wdog_timer_chk #(
  parameter int CW = 16,
  parameter logic [CW-1:0] SVC_KEY = 16'hB00C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          irq,
  input logic          wdt_rst,
  input logic          wd_mode,
  input logic          act_irq,
  input logic [1:0]    psel,
  input logic [CW-1:0] load_q
);
  // R6
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) wd_mode |=> wd_mode);
  // R9
  load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) wd_mode |=> $stable(load_q));
  // R9
  psel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) wd_mode |=> $stable(psel));
  // R8
  svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && wr_data == SVC_KEY) |=> !irq);
  // R10
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(wd_mode && !act_irq));
endmodule

bind wdog_timer wdog_timer_chk #(.CW(CW), .SVC_KEY(SVC_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq(irq), .wdt_rst(wdt_rst), .wd_mode(ctrl_q[5]), .act_irq(ctrl_q[1]),
  .psel(ctrl_q[3:2]), .load_q(load_q)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam logic [15:0] KEY = 16'hB00C;
  logic clk = 0, rst_n = 0, src_tick = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] count;
  logic irq, wdt_rst;
  int n_chk = 0, n_fail = 0;
  bit mchk = 0;

  always #5 clk = ~clk;

  wdog_timer u_dut (.clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .irq(irq), .wdt_rst(wdt_rst));

  logic [7:0] m_ctrl;
  logic [15:0] m_load, m_cnt;
  logic [7:0] m_pc;
  logic m_irq, m_rst;

  function automatic logic [7:0] divm1(input logic [1:0] s);
    return s == 2'b01 ? 8'd15 : (s == 2'b10 ? 8'd255 : 8'd0);
  endfunction

  function automatic logic [15:0] next_cnt(input logic [7:0] c, input logic [15:0] v,
                                           input logic [15:0] ld);
    logic dn = c[5] | ~c[0];
    if (dn) return (v == 0) ? ((c[5] | c[6]) ? ld : 16'hFFFF) : v - 1;
    return (v == 16'hFFFF) ? (c[6] ? ld : 16'h0) : v + 1;
  endfunction

  function automatic logic is_end(input logic [7:0] c, input logic [15:0] v);
    return (c[5] | ~c[0]) ? (v == 0) : (v == 16'hFFFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_load = 0; m_cnt = 0; m_pc = 0; m_irq = 0; m_rst = 0;
    end else begin
      logic wd, svc, ldw, ent, run, stp, ex;
      logic [7:0] oc;
      wd  = m_ctrl[5];
      oc  = m_ctrl;
      svc = wr_en && wr_addr == 2 && wr_data == KEY;
      ldw = wr_en && wr_addr == 0 && !wd;
      ent = wr_en && wr_addr == 1 && !wd && wr_data[5];
      run = wd | m_ctrl[7];
      stp = run && src_tick && m_pc >= divm1(m_ctrl[3:2]) && !(svc | ldw | ent);
      ex  = stp && is_end(oc, m_cnt);
      m_rst = ex && wd && !oc[1];
      if (svc) m_irq = 0; else if (ex && (!wd || oc[1])) m_irq = 1;
      if (ldw) begin m_load = wr_data; m_cnt = wr_data; m_pc = 0; end
      else if (ent || svc) begin m_cnt = m_load; m_pc = 0; end
      else if (run && src_tick) begin
        if (stp) begin m_cnt = next_cnt(oc, m_cnt, m_load); m_pc = 0; end
        else m_pc = m_pc + 1;
      end
      if (wr_en && wr_addr == 1) m_ctrl = wd ? {oc[7:2], wr_data[1], oc[0]} : wr_data[7:0];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (mchk && rst_n)
      check(m_ctrl[5] ? "R7 model" : "R4 model", {count, irq, wdt_rst}, {m_cnt, m_irq, m_rst});

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic do_reset();
    mchk = 0; src_tick = 0; wr_en = 0; rst_n = 0;
    cyc(2);
    rst_n = 1;
    cyc(1);
    mchk = 1;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1
    check("R1 reset", {count, irq, wdt_rst}, 0);
    // R2
    wr(0, 16'd5); check("R2 load", count, 5);
    // R4 periodic down, R10 no reset pulse
    wr(1, 16'h00C0); src_tick = 1;
    cyc(5); check("R4 reach zero", count, 0);
    cyc(1); check("R4 reload", {count, irq}, {16'd5, 1'b1});
    check("R10 normal no rst", wdt_rst, 0);
    src_tick = 0;
    // R8
    wr(2, 16'h1234); check("R8 bad key", irq, 1);
    wr(2, KEY); check("R8 good key", irq, 0);
    // R5
    wr(0, 16'hFFFE); wr(1, 16'h0081); src_tick = 1;
    cyc(2); check("R5 up wrap", {count, irq}, {16'h0, 1'b1});
    src_tick = 0;
    // R3
    do_reset();
    wr(0, 16'd100); wr(1, 16'h0084); src_tick = 1;
    cyc(15); check("R3 div16 hold", count, 100);
    cyc(1); check("R3 div16 step", count, 99);
    src_tick = 0;
    // R6 / R7 reset action
    do_reset();
    wr(0, 16'd3); wr(1, 16'h0020);
    check("R6 enter", count, 3);
    src_tick = 1;
    cyc(3); check("R6 down", {count, wdt_rst}, {16'd0, 1'b0});
    cyc(1); check("R7 rst pulse", {count, wdt_rst, irq}, {16'd3, 1'b1, 1'b0});
    cyc(1); check("R7 pulse one cycle", wdt_rst, 0);
    src_tick = 0;
    // R9
    wr(0, 16'h0100); wr(2, KEY); check("R9 load locked", count, 3);
    wr(1, 16'h000A); check("R9 mode kept", count, 3);
    src_tick = 1;
    cyc(1); check("R9 prescale locked", count, 2);
    cyc(3); check("R7 irq action", {irq, wdt_rst, count}, {1'b1, 1'b0, 16'd3});
    src_tick = 0;
    // random normal mode
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      src_tick = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) begin
        logic [1:0] a = 2'($urandom % 4);
        logic [15:0] d = 16'($urandom);
        if (a == 1) d[5] = 0;
        if (a == 0 && ($urandom % 2)) d = 16'($urandom % 40);
        if (a == 2 && ($urandom % 2)) d = KEY;
        wr(a, d);
      end else cyc(1);
    end
    // random watchdog mode
    do_reset();
    wr(0, 16'd25); wr(1, 16'h0020 | 16'($urandom % 2) << 1);
    for (int i = 0; i < 3000; i++) begin
      src_tick = ($urandom % 2) == 0;
      if (($urandom % 10) == 0) begin
        logic [1:0] a = 2'($urandom % 4);
        logic [15:0] d = 16'($urandom);
        if (a == 2 && ($urandom % 4) != 0) d = KEY;
        wr(a, d);
      end else cyc(1);
    end
    mchk = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule